// File: doc/BRIEF.md
# Stretchable External Data-Memory Access Sequencer

This block runs one external data-memory access at a time for a fast 8051-style core. The core supplies a start request with a read/write flag, a 16-bit address and, for writes, a data byte. The block then steps through a fixed sequence of clocks. It pulses an address latch enable, puts the low address byte on an 8-bit multiplexed port and then turns that port over to data. It keeps the high address byte on a separate port. It drives an active-low read or write strobe and, on a read, captures the returned byte. A machine cycle is four clocks. Each access lasts the stretch setting plus two machine cycles.

A 3-bit stretch setting widens the strobe in 4-clock steps, so one bus serves both fast and slow memories or peripherals. The setting resets to 1. The core may rewrite it at any time. The block samples it only when an access is accepted, so a change made during an access takes effect from the next one. While an access runs, busy is high and further requests are ignored. A one-clock done pulse closes every access.

Top module: `xbus_data_seq`

## Requirements
- R1: While reset is active and after it is released, rd_n, wr_n and psen_n are high, ale is low, ad_oe is low, busy is low and done is low.
- R2: A request is accepted on a rising edge where req_valid is high and busy is low. The next clock is access index 0. With stretch S, done is high for exactly one clock, at index 4*(S+2). busy is high from index 0 through the done clock and low on the following clock. Address and data are latched at acceptance.
- R3: After reset the stretch setting is 1, so the first access has its done clock at index 12.
- R4: With S = 0 the strobe is low for 2 clocks, indices 5 and 6. With S > 0 it is low for 4*S clocks, starting at index 4. rd_n is the strobe for reads and wr_n for writes. The other strobe stays high, and the two are never low together.
- R5: ale is high on indices 0 and 1 only. ad_oe is high and ad_out equals address bits 7:0 on indices 0 to 2. Neither strobe is low while ale is high.
- R6: addr_hi equals address bits 15:8 from index 0 through the done clock.
- R7: On a write, ad_oe is high and ad_out equals the write byte from index 3 through the first clock after wr_n rises. ad_oe is low from the next clock on.
- R8: On a read, ad_oe is low from index 3 onward, so the port is released before rd_n falls. rdata takes the ad_in value on the clock edge where rd_n rises and shows it on the done clock.
- R9: psen_n is high at all times, including during data accesses and reset.
- R10: A pulse on cfg_we loads cfg_stretch into the stretch setting. An access uses the setting held when it was accepted, even if a new value is written while it runs. The new value applies to the next access.
- R11: A request made while busy is high, including on the done clock, is ignored and does not start another access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Start request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| cfg_we | input | 1 | Load strobe for the stretch setting |
| cfg_stretch | input | 3 | New stretch value |
| busy | output | 1 | Access in progress; requests are ignored |
| done | output | 1 | One-clock end-of-access pulse |
| rdata | output | 8 | Byte captured by the last read |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program-store enable, held inactive |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Multiplexed port, outgoing value |
| ad_oe | output | 1 | Multiplexed port output enable |
| ad_in | input | 8 | Multiplexed port, incoming value |

## Verification
Directed accesses use stretch 0 and stretch 7, with both reads and writes. These separate the short-strobe case at index 5 from the 4-clock-step case at index 4, and test the longest counter range. During reads the bench places the expected byte on ad_in only in the clock just before rd_n rises, so a capture one clock early or late yields the complement. One access rewrites the stretch setting and pokes req_valid while busy and on its done clock, to show that the running access keeps its latched length and that no second access starts. Seeded random accesses then mix direction, address, data and stretch, and every clock is compared with windows computed from the stretch value.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/xbus_rst_sync.sv
module xbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/xbus_stretch_reg.sv
module xbus_stretch_reg #(
  parameter int STR_W     = 3,
  parameter int RESET_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [STR_W-1:0] cfg_val,
  output logic [STR_W-1:0] stretch_q
);
  logic [STR_W-1:0] stretch_d;

  always_comb begin
    stretch_d = stretch_q;
    if (cfg_we) stretch_d = cfg_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stretch_q <= STR_W'(RESET_VAL);
    else        stretch_q <= stretch_d;
  end

  // R10: a write lands in the setting on the next clock
  assert_cfg_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (stretch_q == $past(cfg_val)));
endmodule

// File: rtl/xbus_seq_ctrl.sv
module xbus_seq_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int STR_W      = 3,
  parameter int CLK_PER_MC = 4,
  parameter int BASE_MC    = 2,
  parameter int CNT_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [STR_W-1:0]  stretch_cfg,
  output logic              run,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [STR_W-1:0]  lat_stretch_q,
  output logic              lat_write_q,
  output logic [ADDR_W-1:0] lat_addr_q,
  output logic [DATA_W-1:0] lat_wdata_q
);
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last_idx;
  logic             accept;

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign last_idx = CNT_W'((int'(lat_stretch_q) + BASE_MC) * CLK_PER_MC - 1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (cnt_q == last_idx) state_d = ST_DONE;
        else                   cnt_d   = cnt_q + CNT_W'(1);
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // request latches, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_stretch_q <= '0;
      lat_write_q   <= 1'b0;
      lat_addr_q    <= '0;
      lat_wdata_q   <= '0;
    end else if (accept) begin
      lat_stretch_q <= stretch_cfg;
      lat_write_q   <= req_write;
      lat_addr_q    <= req_addr;
      lat_wdata_q   <= req_wdata;
    end
  end

  assign run  = (state_q == ST_RUN);
  assign done = (state_q == ST_DONE);
  assign busy = (state_q != ST_IDLE);

  // R2: acceptance starts the access at index 0
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> (run && cnt_q == '0));
  // R2: done lasts one clock and frees the block
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R10, R11: the latched request is frozen while an access runs
  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(lat_stretch_q) && $stable(lat_addr_q) && $stable(lat_write_q)));
  // R2: the index never runs past the programmed length
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= last_idx));
endmodule

// File: rtl/xbus_phase_decode.sv
module xbus_phase_decode #(
  parameter int STR_W      = 3,
  parameter int CLK_PER_MC = 4,
  parameter int CNT_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [STR_W-1:0] stretch,
  input  logic             is_write,
  output logic             ale_on,
  output logic             addr_phase,
  output logic             data_drive,
  output logic             rd_strobe,
  output logic             wr_strobe,
  output logic             sample_now
);
  localparam int ALE_W       = CLK_PER_MC / 2;
  localparam int ADDR_LAST   = ALE_W;
  localparam int SHORT_START = CLK_PER_MC + CLK_PER_MC / 4;
  localparam int SHORT_LEN   = CLK_PER_MC / 2;

  logic [CNT_W-1:0] stb_start;
  logic [CNT_W-1:0] stb_end;
  logic             in_stb;

  always_comb begin
    if (stretch == '0) begin
      stb_start = CNT_W'(SHORT_START);
      stb_end   = CNT_W'(SHORT_START + SHORT_LEN);
    end else begin
      stb_start = CNT_W'(CLK_PER_MC);
      stb_end   = CNT_W'(CLK_PER_MC + CLK_PER_MC * int'(stretch));
    end
  end

  assign in_stb     = run && (cnt >= stb_start) && (cnt < stb_end);
  assign ale_on     = run && (cnt < CNT_W'(ALE_W));
  assign addr_phase = run && (cnt <= CNT_W'(ADDR_LAST));
  assign data_drive = run && is_write && (cnt > CNT_W'(ADDR_LAST)) && (cnt <= stb_end);
  assign rd_strobe  = in_stb && !is_write;
  assign wr_strobe  = in_stb && is_write;
  assign sample_now = run && !is_write && (cnt == stb_end - CNT_W'(1));

  // R4: at most one strobe active
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_strobe, wr_strobe}));
  // R5: no strobe during the address latch pulse
  assert_ale_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ale_on |-> (!rd_strobe && !wr_strobe));
  // R8: port released while reading
  assert_rd_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> (!addr_phase && !data_drive));
  // R8: capture happens on the last strobe clock
  assert_sample_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now |=> !rd_strobe);
endmodule

// File: rtl/xbus_data_seq.sv
module xbus_data_seq #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int STR_W       = 3,
  parameter int CLK_PER_MC  = 4,
  parameter int BASE_MC     = 2,
  parameter int RESET_STR   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic                    cfg_we,
  input  logic [STR_W-1:0]        cfg_stretch,
  output logic                    busy,
  output logic                    done,
  output logic [DATA_W-1:0]       rdata,
  output logic                    ale,
  output logic                    psen_n,
  output logic                    rd_n,
  output logic                    wr_n,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]       ad_out,
  output logic                    ad_oe,
  input  logic [DATA_W-1:0]       ad_in
);
  localparam int MAX_LEN = ((1 << STR_W) - 1 + BASE_MC) * CLK_PER_MC;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic              srst_n;
  logic [STR_W-1:0]  stretch_q;
  logic              run;
  logic [CNT_W-1:0]  cnt;
  logic [STR_W-1:0]  lat_stretch;
  logic              lat_write;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic              ale_on, addr_phase, data_drive, rd_strobe, wr_strobe, sample_now;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  xbus_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  xbus_stretch_reg #(.STR_W(STR_W), .RESET_VAL(RESET_STR)) u_str (
    .clk(clk), .rst_n(srst_n), .cfg_we(cfg_we), .cfg_val(cfg_stretch),
    .stretch_q(stretch_q)
  );

  xbus_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STR_W(STR_W),
    .CLK_PER_MC(CLK_PER_MC), .BASE_MC(BASE_MC), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(srst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .stretch_cfg(stretch_q),
    .run(run), .busy(busy), .done(done), .cnt_q(cnt),
    .lat_stretch_q(lat_stretch), .lat_write_q(lat_write),
    .lat_addr_q(lat_addr), .lat_wdata_q(lat_wdata)
  );

  xbus_phase_decode #(
    .STR_W(STR_W), .CLK_PER_MC(CLK_PER_MC), .CNT_W(CNT_W)
  ) u_dec (
    .clk(clk), .rst_n(srst_n),
    .run(run), .cnt(cnt), .stretch(lat_stretch), .is_write(lat_write),
    .ale_on(ale_on), .addr_phase(addr_phase), .data_drive(data_drive),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .sample_now(sample_now)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (sample_now) rdata_d = ad_in;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata   = rdata_q;
  assign ale     = ale_on;
  assign psen_n  = 1'b1;
  assign rd_n    = !rd_strobe;
  assign wr_n    = !wr_strobe;
  assign ad_oe   = addr_phase || data_drive;
  assign ad_out  = addr_phase ? lat_addr[DATA_W-1:0] : (data_drive ? lat_wdata : '0);
  assign addr_hi = lat_addr[ADDR_W-1:DATA_W];

  // R7: write data on the port for the whole write strobe
  assert_wr_data_R7: assert property (@(posedge clk) disable iff (!srst_n)
    !wr_n |-> (ad_oe && ad_out == lat_wdata));
  // R8: port floats while reading
  assert_rd_float_R8: assert property (@(posedge clk) disable iff (!srst_n)
    !rd_n |-> !ad_oe);
  // R7: data held one clock past the write strobe
  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(wr_n) |-> (ad_oe && ad_out == lat_wdata));
  // R1, R2: no strobe outside an access
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!srst_n)
    !busy |-> (rd_n && wr_n && !ale && !ad_oe));
endmodule

// File: tb/xbus_data_seq_test.sv
module xbus_data_seq_test;
  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write, cfg_we;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, ad_in;
  logic [2:0]  cfg_stretch;
  logic        busy, done, ale, psen_n, rd_n, wr_n, ad_oe;
  logic [7:0]  rdata, addr_hi, ad_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int model_s;

  xbus_data_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .cfg_we(cfg_we),
    .cfg_stretch(cfg_stretch), .busy(busy), .done(done), .rdata(rdata),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected<=150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic check_eq(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int exp_len(input int s);
    return 4 * (s + 2);
  endfunction
  function automatic int exp_slen(input int s);
    return (s == 0) ? 2 : 4 * s;
  endfunction
  function automatic int exp_sstart(input int s);
    return (s == 0) ? 5 : 4;
  endfunction

  task automatic set_stretch(input int s);
    cfg_we = 1'b1;
    cfg_stretch = 3'(s);
    @(negedge clk);
    cfg_we = 1'b0;
    model_s = s;
  endtask

  // entered and left at a falling edge
  task automatic run_access(input bit wr, input logic [15:0] addr, input logic [7:0] wd,
                            input logic [7:0] rv, input int mid_cfg, input bit poke,
                            output int kdone);
    int s, n, st, en;
    int ale_bad, stb_bad, oe_bad, dat_bad, hi_bad, ps_bad, busy_bad, slen;
    bit e_rd, e_wr, e_oe;
    logic [7:0] e_dat;
    s = model_s; n = exp_len(s); st = exp_sstart(s); en = st + exp_slen(s);
    ale_bad = 0; stb_bad = 0; oe_bad = 0; dat_bad = 0; hi_bad = 0; ps_bad = 0;
    busy_bad = 0; slen = 0; kdone = -1;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; ad_in = ~rv;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~addr; req_wdata = ~wd;
    for (int k = 0; k < 64; k++) begin
      e_rd  = !wr && k >= st && k < en;
      e_wr  = wr && k >= st && k < en;
      e_oe  = (k < n) && (k <= 2 || (wr && k <= en));
      e_dat = (k <= 2) ? addr[7:0] : wd;
      if (ale !== (k < 2)) ale_bad++;
      if (rd_n !== !e_rd || wr_n !== !e_wr) stb_bad++;
      if ((wr && !wr_n) || (!wr && !rd_n)) slen++;
      if (ad_oe !== e_oe) oe_bad++;
      else if (e_oe && ad_out !== e_dat) dat_bad++;
      if (addr_hi !== addr[15:8]) hi_bad++;
      if (psen_n !== 1'b1) ps_bad++;
      if (busy !== 1'b1) busy_bad++;
      if (done === 1'b1) begin
        kdone = k;
        if (!wr) check_eq("R8", "read byte at done", int'(rdata), int'(rv));
      end
      ad_in = (!wr && k == en - 1) ? rv : ~rv;
      if (k == 3) begin
        if (mid_cfg >= 0) begin cfg_we = 1'b1; cfg_stretch = 3'(mid_cfg); end
        if (poke) begin req_valid = 1'b1; req_addr = 16'h0000; end
      end
      if (k == 4) begin cfg_we = 1'b0; req_valid = 1'b0; end
      if (kdone >= 0) begin
        if (poke) req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
    check_eq("R2", "done index", kdone, n);
    check_eq("R4", "strobe timing mismatches", stb_bad, 0);
    check_eq("R4", "strobe width", slen, exp_slen(s));
    check_eq("R5", "ale mismatches", ale_bad, 0);
    check_eq(wr ? "R7" : "R8", "port enable mismatches", oe_bad, 0);
    check_eq(wr ? "R7" : "R5", "port value mismatches", dat_bad, 0);
    check_eq("R6", "high address mismatches", hi_bad, 0);
    check_eq("R9", "psen_n mismatches", ps_bad, 0);
    check_eq("R2", "busy low inside access", busy_bad, 0);
    check_eq(poke ? "R11" : "R2", "busy after done", int'(busy), 0);
    check_eq("R2", "done after done clock", int'(done), 0);
    @(negedge clk);
    check_eq(poke ? "R11" : "R2", "idle ale/busy/strobes", int'({ale, busy, rd_n, wr_n}), 3);
    if (mid_cfg >= 0) model_s = mid_cfg;
  endtask

  initial begin
    int kd;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    cfg_we = 1'b0; cfg_stretch = '0; ad_in = '0; model_s = 1;
    repeat (3) @(negedge clk);
    check_eq("R1", "strobes/psen in reset", int'({rd_n, wr_n, psen_n}), 7);
    check_eq("R9", "psen_n in reset", int'(psen_n), 1);
    check_eq("R1", "ale/oe/busy/done in reset", int'({ale, ad_oe, busy, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1", "idle after reset", int'({ale, ad_oe, busy, done, rd_n, wr_n, psen_n}), 7);

    run_access(1'b1, 16'hA55A, 8'h3C, 8'h00, -1, 1'b0, kd);
    check_eq("R3", "default stretch access length", kd, 12);
    run_access(1'b0, 16'h1234, 8'h00, 8'hC5, -1, 1'b0, kd);
    check_eq("R3", "default stretch read length", kd, 12);

    set_stretch(0);
    run_access(1'b0, 16'hFF01, 8'h00, 8'h96, -1, 1'b0, kd);
    run_access(1'b1, 16'h00FE, 8'h81, 8'h00, -1, 1'b0, kd);
    set_stretch(7);
    run_access(1'b0, 16'h8000, 8'h00, 8'h5A, -1, 1'b0, kd);
    run_access(1'b1, 16'h7FFF, 8'hE7, 8'h00, -1, 1'b0, kd);

    set_stretch(2);
    run_access(1'b1, 16'h4321, 8'h11, 8'h00, 6, 1'b1, kd);
    check_eq("R10", "running access kept old stretch", kd, 16);
    run_access(1'b0, 16'h2468, 8'h00, 8'h42, -1, 1'b1, kd);
    check_eq("R10", "next access uses new stretch", kd, 32);

    for (int i = 0; i < 24; i++) begin
      bit w;
      logic [15:0] a;
      logic [7:0] d, r;
      if ($urandom_range(0, 2) != 0) set_stretch(int'($urandom_range(0, 7)));
      w = 1'($urandom_range(0, 1));
      a = 16'($urandom);
      d = 8'($urandom);
      r = 8'($urandom);
      run_access(w, a, d, r, -1, 1'($urandom_range(0, 1)), kd);
    end

    summary();
    $finish;
  end
endmodule